// File: doc/BRIEF.md
# Two-Port Shared Execution Unit Arbiter

This block lets two simple processor pipelines share one multi-cycle execution unit instead of each carrying its own. Each port offers an operation code, two operands and a request level. The unit serves one operation at a time. When the operation completes, the unit returns a result word, the index of the port that owns it, and a one-cycle done pulse on that port only.

The arbiter samples requests only while the unit is idle. Every accepted operation first spends one arbitration cycle and then occupies the unit for a fixed number of cycles set by its operation class. A port that asks while the unit is busy, or that loses a tie, is held in a full stall and is not queued. It must keep its request and operands steady until it is served. Ties are broken by round robin. Shifts, integer multiply and unsigned integer divide compute real results. The four floating-point codes only model occupancy and return a fixed placeholder word.

Top module: `shared_xu_arbiter`

## Requirements
- R1: Only one port is served at a time. A done pulse goes only to the port that owns the operation, and `result_port_o` carries that port's index in the done cycle.
- R2: If a request is sampled at clock edge k while the unit is idle, the owner's `done_o` bit is high for exactly the one cycle that follows edge k+1+L, where L is the occupancy of the operation class.
- R3: Operation codes and occupancy L: 0 shift left (2), 1 logical shift right (2), 2 multiply (3), 3 unsigned divide (34), 4 float add (6), 5 float subtract (6), 6 float multiply (6), 7 float divide (30).
- R4: Code 0 returns opa shifted left by opb[4:0]. Code 1 returns opa shifted right logically by opb[4:0].
- R5: Code 2 returns the low 32 bits of the unsigned product opa*opb.
- R6: Code 3 returns the unsigned quotient opa/opb. A zero divisor returns 0xFFFFFFFF.
- R7: Codes 4 to 7 return the placeholder 0x7FC00000.
- R8: When both ports are sampled requesting in the same idle cycle, the port favoured by a priority pointer wins, and the pointer then moves to the loser. After reset the pointer favours port 0. A request from one port alone does not move the pointer.
- R9: `stall_o` of a port is high while that port requests and is neither the owner of the current operation nor receiving its done pulse. The loser of a tie is granted at the edge right after the winner's done cycle.
- R10: The unit is not pipelined. A request that arrives while an operation is in progress is sampled only at the edge after that operation's done cycle.
- R11: Reset clears any operation in flight and any pending grant. While in reset, `done_o` and `result_port_o` are zero and `result_o` is zero. After reset no stale done pulse appears, and the next request gets the normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 2 | Request level per port |
| op_i | input | 2x3 | Operation code per port |
| opa_i | input | 2x32 | First operand per port |
| opb_i | input | 2x32 | Second operand per port |
| stall_o | output | 2 | Port is waiting for the unit |
| done_o | output | 2 | One-cycle completion pulse per port |
| result_o | output | 32 | Result word, valid in the done cycle |
| result_port_o | output | 1 | Index of the port that owns the result |

## Verification
Each of the eight operation codes is swept on each port alone over six operand pairs. The pairs include zero and all-ones operands, a shift of 31, a shift of zero and a zero divisor, so arithmetic faults and off-by-one latency faults show up separately for each class. Simultaneous requests are repeated with different operation mixes, so the round-robin pointer has to alternate the winner. Late requests arrive during a long divide, and they must neither move the pointer nor be granted early. A reset in the middle of a divide must leave no trace of the old operation.

// File: rtl/shared_xu_pkg.sv
package shared_xu_pkg;

  typedef enum logic [2:0] {
    XU_SHL  = 3'd0,
    XU_SHR  = 3'd1,
    XU_MUL  = 3'd2,
    XU_DIV  = 3'd3,
    XU_FADD = 3'd4,
    XU_FSUB = 3'd5,
    XU_FMUL = 3'd6,
    XU_FDIV = 3'd7
  } xu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_BUSY = 2'd2
  } xu_state_e;

  localparam logic [31:0] XU_FP_STUB = 32'h7FC0_0000;

  function automatic int max_int(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/xu_rr_arb.sv
module xu_rr_arb #(
  parameter int N_PORTS = 2,
  localparam int IDX_W  = $clog2(N_PORTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] req_i,
  input  logic               fire_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic [IDX_W-1:0] prio_q;
  logic             tie;
  logic             found;

  always_comb begin
    idx_o = prio_q;
    found = 1'b0;
    for (int k = 0; k < N_PORTS; k++) begin
      if (!found && req_i[(int'(prio_q) + k) % N_PORTS]) begin
        idx_o = IDX_W'((int'(prio_q) + k) % N_PORTS);
        found = 1'b1;
      end
    end
  end

  assign any_o = |req_i;
  assign tie   = $countones(req_i) > 1;

  // pointer moves past the winner only when several ports collide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               prio_q <= '0;
    else if (fire_i && tie)    prio_q <= IDX_W'((int'(idx_o) + 1) % N_PORTS);
  end

  assert_tie_rotates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && tie) |=> (prio_q != $past(prio_q)));

  assert_single_keeps_prio_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !tie) |=> $stable(prio_q));

  assert_grant_is_requester_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> req_i[idx_o]);

endmodule

// File: rtl/xu_seq_div.sv
module xu_seq_div #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic         busy_o
);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    rem_sh;
  logic          ge;

  // restoring division, one quotient bit per cycle
  always_comb begin
    rem_sh = {rem_q, quo_q[W-1]};
    ge     = rem_sh >= {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      rem_q <= '0;
      quo_q <= num_i;
      den_q <= den_i;
      cnt_q <= CW'(W);
    end else if (cnt_q != '0) begin
      rem_q <= ge ? W'(rem_sh - {1'b0, den_q}) : rem_sh[W-1:0];
      quo_q <= {quo_q[W-2:0], ge};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign quo_o  = quo_q;
  assign busy_o = (cnt_q != '0);

  assert_div_start_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);

  assert_div_runs_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/xu_exec.sv
module xu_exec
  import shared_xu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  xu_op_e            op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output xu_op_e            op_o,
  output logic [DATA_W-1:0] result_o
);

  xu_op_e            op_q;
  logic [DATA_W-1:0] a_q, b_q, quo;
  logic              div_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= XU_SHL;
      a_q  <= '0;
      b_q  <= '0;
    end else if (load_i) begin
      op_q <= op_i;
      a_q  <= a_i;
      b_q  <= b_i;
    end
  end

  xu_seq_div #(.W(DATA_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(load_i && (op_i == XU_DIV)),
    .num_i  (a_i),
    .den_i  (b_i),
    .quo_o  (quo),
    .busy_o (div_busy)
  );

  always_comb begin
    unique case (op_q)
      XU_SHL:  result_o = a_q << b_q[SH_W-1:0];
      XU_SHR:  result_o = a_q >> b_q[SH_W-1:0];
      XU_MUL:  result_o = a_q * b_q;
      XU_DIV:  result_o = quo;
      default: result_o = DATA_W'(XU_FP_STUB);
    endcase
  end

  assign op_o = op_q;

  assert_operands_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !$past(load_i)) |-> ($stable(a_q) && $stable(b_q)));

  assert_div_done_before_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == XU_DIV && $fell(div_busy)) |-> !load_i);

endmodule

// File: rtl/shared_xu_arbiter.sv
module shared_xu_arbiter
  import shared_xu_pkg::*;
#(
  parameter int N_PORTS   = 2,
  parameter int DATA_W    = 32,
  parameter int LAT_SHIFT = 2,
  parameter int LAT_MUL   = 3,
  parameter int LAT_DIV   = 34,   // must be >= DATA_W
  parameter int LAT_FPS   = 6,
  parameter int LAT_FDIV  = 30,
  localparam int IDX_W    = $clog2(N_PORTS),
  localparam int LAT_MAX  = max_int(max_int(LAT_SHIFT, LAT_MUL),
                                    max_int(LAT_DIV, max_int(LAT_FPS, LAT_FDIV))),
  localparam int CNT_W    = $clog2(LAT_MAX + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PORTS-1:0]             req_i,
  input  logic [N_PORTS-1:0][2:0]        op_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] opa_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] opb_i,
  output logic [N_PORTS-1:0]             stall_o,
  output logic [N_PORTS-1:0]             done_o,
  output logic [DATA_W-1:0]              result_o,
  output logic [IDX_W-1:0]               result_port_o
);

  function automatic int lat_of(input xu_op_e op);
    case (op)
      XU_SHL, XU_SHR:           return LAT_SHIFT;
      XU_MUL:                   return LAT_MUL;
      XU_DIV:                   return LAT_DIV;
      XU_FADD, XU_FSUB, XU_FMUL: return LAT_FPS;
      default:                  return LAT_FDIV;
    endcase
  endfunction

  xu_state_e         st_q;
  logic [IDX_W-1:0]  owner_q, gnt_idx;
  logic [CNT_W-1:0]  cnt_q;
  logic [N_PORTS-1:0] done_q;
  logic [DATA_W-1:0] res_q, dp_res;
  logic              any_req, fire, load;
  xu_op_e            cur_op;

  assign fire = (st_q == ST_IDLE);
  assign load = fire && any_req;

  xu_rr_arb #(.N_PORTS(N_PORTS)) i_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .fire_i(fire),
    .any_o (any_req),
    .idx_o (gnt_idx)
  );

  xu_exec #(.DATA_W(DATA_W)) i_exec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .op_i    (xu_op_e'(op_i[gnt_idx])),
    .a_i     (opa_i[gnt_idx]),
    .b_i     (opb_i[gnt_idx]),
    .op_o    (cur_op),
    .result_o(dp_res)
  );

  // idle -> arbitration cycle -> fixed occupancy -> done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      owner_q <= '0;
      cnt_q   <= '0;
      done_q  <= '0;
      res_q   <= '0;
    end else begin
      done_q <= '0;
      unique case (st_q)
        ST_IDLE: if (any_req) begin
          owner_q <= gnt_idx;
          st_q    <= ST_ARB;
        end
        ST_ARB: begin
          cnt_q <= CNT_W'(lat_of(cur_op) - 1);
          st_q  <= ST_BUSY;
        end
        ST_BUSY: if (cnt_q == '0) begin
          done_q[owner_q] <= 1'b1;
          res_q           <= dp_res;
          st_q            <= ST_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int p = 0; p < N_PORTS; p++) begin
      stall_o[p] = req_i[p] && !done_q[p] &&
                   !((st_q != ST_IDLE) && (owner_q == IDX_W'(p)));
    end
  end

  assign done_o        = done_q;
  assign result_o      = res_q;
  assign result_port_o = owner_q;

  // independent occupancy counter for the latency check
  logic [CNT_W:0] occ_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              occ_q <= '0;
    else if (load)            occ_q <= (CNT_W+1)'(1);
    else if (occ_q != '1)     occ_q <= occ_q + 1'b1;
  end

  assert_done_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |-> (occ_q == (CNT_W+1)'(lat_of(cur_op) + 2)));

  assert_arb_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARB) |=> (st_q == ST_BUSY));

  assert_no_regrant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY) |=> (st_q != ST_ARB));

  assert_done_frees_unit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |-> (st_q == ST_IDLE));

  for (genvar p = 0; p < N_PORTS; p++) begin : g_hold
    assert_hold_while_stalled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o[p] |=> (req_i[p] && $stable(op_i[p]) && $stable(opa_i[p]) && $stable(opb_i[p])));
  end

endmodule

// File: tb/test_shared_xu_arbiter.sv
module test_shared_xu_arbiter;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       req = '0;
  logic [1:0][2:0]  op = '0;
  logic [1:0][31:0] opa = '0;
  logic [1:0][31:0] opb = '0;
  logic [1:0]       stall, done;
  logic [31:0]      result;
  logic             rport;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int prio = 0;

  always #2 clk = ~clk;

  shared_xu_arbiter i_shared_xu_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .opa_i(opa), .opb_i(opb),
    .stall_o(stall), .done_o(done), .result_o(result), .result_port_o(rport)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_lat(input int o);
    case (o)
      0, 1: return 2;
      2: return 3;
      3: return 34;
      7: return 30;
      default: return 6;
    endcase
  endfunction

  function automatic logic [31:0] exp_res(input int o, input logic [31:0] a, input logic [31:0] b);
    case (o)
      0: return a << b[4:0];
      1: return a >> b[4:0];
      2: return a * b;
      3: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      default: return 32'h7FC0_0000;
    endcase
  endfunction

  function automatic string res_tag(input int o);
    case (o)
      0, 1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_one(input int p, input int o, input logic [31:0] a, input logic [31:0] b);
    int c = 0;
    bit got = 0;
    @(negedge clk);
    req[p] = 1'b1; op[p] = 3'(o); opa[p] = a; opb[p] = b;
    while (!got && c < 100) begin
      @(posedge clk); @(negedge clk); c++;
      if (done != 0) got = 1;
    end
    chk("R2", "latency", 32'(c), 32'(exp_lat(o) + 2));   // R3 occupancy by code
    chk("R1", "done owner", 32'(done), 32'(1 << p));
    chk("R1", "result port", 32'(rport), 32'(p));
    chk(res_tag(o), "result", result, exp_res(o, a, b));
    req[p] = 1'b0;
  endtask

  // d0/d1: cycle after which each port raises its request; the earlier one uses 0
  task automatic contend(input int o0, input logic [31:0] a0, input logic [31:0] b0, input int d0,
                         input int o1, input logic [31:0] a1, input logic [31:0] b1, input int d1);
    int w, l, c, cw, cl, dl;
    int o[2];
    logic [31:0] av[2], bv[2];
    o[0] = o0; o[1] = o1; av[0] = a0; av[1] = a1; bv[0] = b0; bv[1] = b1;
    if (d0 == d1) begin w = prio; prio = 1 - prio; end
    else w = (d0 < d1) ? 0 : 1;
    l  = 1 - w;
    dl = (l == 0) ? d0 : d1;
    cw = 0; cl = 0; c = 0;
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      op[p] = 3'(o[p]); opa[p] = av[p]; opb[p] = bv[p];
      if (((p == 0) ? d0 : d1) == 0) req[p] = 1'b1;
    end
    while ((cw == 0 || cl == 0) && c < 200) begin
      @(posedge clk); @(negedge clk); c++;
      if (cw == 0 && c >= dl + 1) chk("R9", "loser stalled", 32'(stall[l]), 32'd1);
      if (cw == 0) chk("R9", "winner not stalled", 32'(stall[w]), 32'd0);
      if (done[w]) begin
        cw = c;
        chk(res_tag(o[w]), "winner result", result, exp_res(o[w], av[w], bv[w]));
        chk("R1", "winner port", 32'(rport), 32'(w));
        req[w] = 1'b0;
      end
      if (done[l]) begin
        cl = c;
        chk(res_tag(o[l]), "loser result", result, exp_res(o[l], av[l], bv[l]));
        chk("R1", "loser port", 32'(rport), 32'(l));
        req[l] = 1'b0;
      end
      if (c == dl && dl > 0) req[l] = 1'b1;
    end
    chk("R8", "winner done cycle", 32'(cw), 32'(exp_lat(o[w]) + 2));
    chk("R10", "loser done cycle", 32'(cl), 32'(exp_lat(o[w]) + 2 + exp_lat(o[l]) + 2));
  endtask

  initial begin
    logic [31:0] pa[6], pb[6];
    pa[0] = 32'h1234_5678; pb[0] = 32'd4;
    pa[1] = 32'hFFFF_FFFF; pb[1] = 32'd31;
    pa[2] = 32'h8000_0001; pb[2] = 32'd0;
    pa[3] = 32'h0;         pb[3] = 32'hFFFF_FFFF;
    pa[4] = 32'd12345;     pb[4] = 32'd0;
    pa[5] = 32'hDEAD_BEEF; pb[5] = 32'h0001_0003;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "done in reset", 32'(done), 32'd0);
    chk("R11", "result in reset", result, 32'd0);
    chk("R11", "port in reset", 32'(rport), 32'd0);
    chk("R9", "stall without request", 32'(stall), 32'd0);
    rst_n = 1'b1;

    // sweep every code on both ports alone
    for (int p = 0; p < 2; p++)
      for (int o = 0; o < 8; o++)
        for (int k = 0; k < 6; k++)
          run_one(p, o, pa[k], pb[k]);

    // ties and late arrivals
    contend(0, 32'hA5A5_0001, 32'd7, 0, 2, 32'd65537, 32'd65535, 0);
    contend(3, 32'd1000000, 32'd7, 0, 4, 32'd1, 32'd2, 0);
    contend(7, 32'd5, 32'd6, 0, 3, 32'hFFFF_FFFF, 32'd3, 0);
    contend(3, 32'h8000_0000, 32'd3, 0, 1, 32'hF000_0000, 32'd28, 5);
    contend(6, 32'd9, 32'd9, 2, 2, 32'd3, 32'd5, 0);
    contend(5, 32'd1, 32'd1, 0, 0, 32'd1, 32'd31, 0);

    // R11: reset in the middle of a divide
    @(negedge clk);
    req[0] = 1'b1; op[0] = 3'd3; opa[0] = 32'd100; opb[0] = 32'd3;
    repeat (6) @(negedge clk);
    rst_n = 1'b0; req[0] = 1'b0;
    @(negedge clk);
    chk("R11", "done cleared by reset", 32'(done), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    prio = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done != 0) chk("R11", "stale done after reset", 32'(done), 32'd0);
    end
    checks++;
    run_one(1, 0, 32'h0000_00FF, 32'd8);
    contend(1, 32'h8000_0000, 32'd1, 0, 1, 32'h4000_0000, 32'd2, 0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule